// File: doc/BRIEF.md
# Final-Stage Radix-2 Butterfly Combiner

This block is the closing radix-2 stage of a 16-point transform that has been split into two 8-point halves. One input port carries the 8-point result of the even-indexed samples, E(k), already put back into natural order. The other carries the 8-point result of the odd-indexed samples, O(k), which leaves a decimation-in-time core in natural order. Each accepted pair is one bin k. The block rotates O(k) by the twiddle factor W16^k and forms the sum and the difference. So on every accepted pair it delivers two spectrum bins at once: X(k) on the low output port and X(k+8) on the high output port.

The bin counter is internal, so the outputs leave in natural order with no reorder buffer after the block. All arithmetic is fixed point with 16-bit signed real and imaginary parts. The twiddles are held as signed Q1.15 constants. The product is rounded and clamped, and the final sum and difference are halved, so that a full-scale input cannot overflow the output word.

Top module: `fft_final_bfly`

## Requirements
- R1: While rst_n is low at a rising clock edge (synchronous, active low), both output valids, all output data and o_bin are cleared to 0, and the bin counter returns to 0.
- R2: The low port gives X(k) = (E(k) + P(k) + 1) >>> 1 per real and imaginary part, where P(k) is the rotated odd operand of R7 and R8.
- R3: The high port gives X(k+8) = (E(k) − P(k) + 1) >>> 1 per part, in the same clock as X(k).
- R4: A pair is accepted only on a clock where ev_vld and od_vld are both high. Both output valids rise exactly two clocks after an accepted pair. A lone ev_vld or a lone od_vld produces no output.
- R5: The bin index k starts at 0 on the first accepted pair after reset, rises by one per accepted pair, and wraps from 7 to 0. o_bin carries the k of the bins on the outputs.
- R6: The twiddle for bin k has real part round(cos(2πk/16)·32768) and imaginary part round(−sin(2πk/16)·32768), each clamped to ±32767. This gives W0 = (32767, 0) and W4 = (0, −32767).
- R7: Before clamping, P = O·W is computed as re = Ore·Wre − Oim·Wim and im = Ore·Wim + Oim·Wre. Each part is rounded by adding 2^14 and shifting arithmetically right by 15. Each part is then clamped to the range [−32767, 32767].
- R8: The halving in R2 and R3 rounds to nearest, with ties toward +infinity. As a result, X(k) + X(k+8) − E(k) is 0 or 1 in each part.
- R9: While the output valids are low, all output data and o_bin hold their last values.
- R10: Clocks with no accepted pair, whether idle or with only one valid, leave the bin counter unchanged, so bins stay in order across gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_vld | input | 1 | Even-half operand valid |
| ev_re | input | 16 | Even-half operand E(k), real, signed |
| ev_im | input | 16 | Even-half operand E(k), imaginary, signed |
| od_vld | input | 1 | Odd-half operand valid |
| od_re | input | 16 | Odd-half operand O(k), real, signed |
| od_im | input | 16 | Odd-half operand O(k), imaginary, signed |
| lo_vld | output | 1 | Low output valid |
| lo_re | output | 16 | X(k), real, signed |
| lo_im | output | 16 | X(k), imaginary, signed |
| hi_vld | output | 1 | High output valid |
| hi_re | output | 16 | X(k+8), real, signed |
| hi_im | output | 16 | X(k+8), imaginary, signed |
| o_bin | output | 3 | Bin index k of the current outputs |

## Verification
The assertions assume that the even and odd producers are aligned: the operands of one bin are offered on the same clock with both valids high. They also assume that rst_n is held low for at least two clocks, and that no valid is raised while reset is low. The bench drives every pair with both valids on one clock and keeps both valids low throughout reset. It raises a single valid only on purpose, to show that such a clock is ignored. Operand values cover full-scale corners in both signs, so the clamp and the sum-pair relation are exercised at their limits without leaving the 16-bit input range.

// File: rtl/fbc_pkg.sv
// Package: shared types and twiddle constants of the final butterfly combiner.
// Assumes a 16-point transform; twiddles are signed Q1.15, W16^k = cos - j*sin.
package fbc_pkg;

    localparam int CW = 16;

    typedef struct packed {
        logic [CW-1:0] re;
        logic [CW-1:0] im;
    } tw_t;

    // Twiddle W16^k for k = 0..7, rounded to Q1.15 and clamped to +/-32767.
    function automatic tw_t tw16(input logic [2:0] k);
        tw_t w;
        case (k)
            3'd0:    begin w.re = 16'sd32767;  w.im = 16'sd0;      end
            3'd1:    begin w.re = 16'sd30274;  w.im = -16'sd12540; end
            3'd2:    begin w.re = 16'sd23170;  w.im = -16'sd23170; end
            3'd3:    begin w.re = 16'sd12540;  w.im = -16'sd30274; end
            3'd4:    begin w.re = 16'sd0;      w.im = -16'sd32767; end
            3'd5:    begin w.re = -16'sd12540; w.im = -16'sd30274; end
            3'd6:    begin w.re = -16'sd23170; w.im = -16'sd23170; end
            default: begin w.re = -16'sd30274; w.im = -16'sd12540; end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fbc_kcount.sv
// Bin counter: counts accepted pairs from 0 to HALF-1 and wraps.
// Assumes adv is high for exactly one clock per accepted operand pair.
module fbc_kcount #(
    parameter int HALF = 8,
    parameter int KW   = $clog2(HALF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [KW-1:0] k
);

    localparam logic [KW-1:0] LAST = KW'(HALF - 1);

    // Advance on each accepted pair, wrapping after the last bin.
    always_ff @(posedge clk) begin
        if (!rst_n)
            k <= '0;
        else if (adv)
            k <= (k == LAST) ? '0 : k + 1'b1;
    end

    p_kwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && k == LAST) |=> (k == '0));

    p_kstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && k != LAST) |=> (k == $past(k) + 1'b1));

    p_khold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(k));

endmodule

// File: rtl/fbc_twiddle.sv
// Twiddle lookup: maps the bin index to its Q1.15 rotation factor.
// Assumes a 16-point transform, i.e. a three-bit bin index.
module fbc_twiddle #(
    parameter int KW = 3
) (
    input  logic [KW-1:0]   k,
    output fbc_pkg::tw_t    w
);

    // Pure combinational table read.
    always_comb begin
        w = fbc_pkg::tw16(3'(k));
    end

endmodule

// File: rtl/fbc_twmul.sv
// First pipeline stage: rotates the odd operand by the twiddle and registers
// the rounded, clamped product alongside the even operand and the bin index.
// Assumes vin marks an accepted pair; data registers only load when vin is high.
module fbc_twmul #(
    parameter int DW = 16,
    parameter int KW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vin,
    input  logic [KW-1:0]        k_in,
    input  logic signed [DW-1:0] e_re,
    input  logic signed [DW-1:0] e_im,
    input  logic signed [DW-1:0] o_re,
    input  logic signed [DW-1:0] o_im,
    input  fbc_pkg::tw_t         w,
    output logic                 v1,
    output logic [KW-1:0]        k1,
    output logic signed [DW-1:0] e1_re,
    output logic signed [DW-1:0] e1_im,
    output logic signed [DW-1:0] p_re,
    output logic signed [DW-1:0] p_im
);

    localparam int CW = fbc_pkg::CW;
    localparam int MW = DW + CW;
    localparam int AW = MW + 1;
    localparam logic signed [AW-1:0] RND     = AW'(2 ** (CW - 2));
    localparam logic signed [AW-1:0] POS_LIM = AW'(2 ** (DW - 1) - 1);
    localparam logic signed [AW-1:0] NEG_LIM = -POS_LIM;

    logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [AW-1:0] acc_re, acc_im, sh_re, sh_im;
    logic signed [DW-1:0] c_re, c_im;
    logic                 unit_w;

    // Symmetric clamp of a rounded product to the data word.
    function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
        if (v > POS_LIM)
            return DW'(POS_LIM);
        else if (v < NEG_LIM)
            return DW'(NEG_LIM);
        else
            return DW'(v);
    endfunction

    // Complex multiply, round to nearest at bit CW-1, then clamp.
    always_comb begin
        m_rr   = o_re * $signed(w.re);
        m_ii   = o_im * $signed(w.im);
        m_ri   = o_re * $signed(w.im);
        m_ir   = o_im * $signed(w.re);
        acc_re = {m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii};
        acc_im = {m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir};
        sh_re  = (acc_re + RND) >>> (CW - 1);
        sh_im  = (acc_im + RND) >>> (CW - 1);
        c_re   = clamp(sh_re);
        c_im   = clamp(sh_im);
        unit_w = (w.re == CW'(2 ** (CW - 1) - 1)) && (w.im == '0);
    end

    // Stage valid follows the input pair strobe every clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            v1 <= 1'b0;
        else
            v1 <= vin;
    end

    // Stage data loads only on an accepted pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k1    <= '0;
            e1_re <= '0;
            e1_im <= '0;
            p_re  <= '0;
            p_im  <= '0;
        end else if (vin) begin
            k1    <= k_in;
            e1_re <= e_re;
            e1_im <= e_im;
            p_re  <= c_re;
            p_im  <= c_im;
        end
    end

    // A unity twiddle changes the operand by at most one LSB per part.
    p_unit_twiddle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vin && unit_w) |->
            ((p_re - $past(o_re)) >= -1 && (p_re - $past(o_re)) <= 1 &&
             (p_im - $past(o_im)) >= -1 && (p_im - $past(o_im)) <= 1));

endmodule

// File: rtl/fbc_addsub.sv
// Second pipeline stage: forms (E+P)/2 and (E-P)/2 with round to nearest and
// registers both bins with their index. Assumes |P| <= 2^(DW-1)-1 so the halved
// results always fit the data word.
module fbc_addsub #(
    parameter int DW = 16,
    parameter int KW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v1,
    input  logic [KW-1:0]        k1,
    input  logic signed [DW-1:0] e_re,
    input  logic signed [DW-1:0] e_im,
    input  logic signed [DW-1:0] p_re,
    input  logic signed [DW-1:0] p_im,
    output logic                 o_vld,
    output logic [KW-1:0]        o_bin,
    output logic signed [DW-1:0] lo_re,
    output logic signed [DW-1:0] lo_im,
    output logic signed [DW-1:0] hi_re,
    output logic signed [DW-1:0] hi_im
);

    localparam logic signed [DW:0] ONE = (DW + 1)'(1);

    logic signed [DW:0] s_re, s_im, d_re, d_im;

    // Widened sum and difference, with the rounding half already added.
    always_comb begin
        s_re = {e_re[DW-1], e_re} + {p_re[DW-1], p_re} + ONE;
        s_im = {e_im[DW-1], e_im} + {p_im[DW-1], p_im} + ONE;
        d_re = {e_re[DW-1], e_re} - {p_re[DW-1], p_re} + ONE;
        d_im = {e_im[DW-1], e_im} - {p_im[DW-1], p_im} + ONE;
    end

    // Output valid follows the stage valid every clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            o_vld <= 1'b0;
        else
            o_vld <= v1;
    end

    // Output data loads only with a valid stage, halving by dropping bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_bin <= '0;
            lo_re <= '0;
            lo_im <= '0;
            hi_re <= '0;
            hi_im <= '0;
        end else if (v1) begin
            o_bin <= k1;
            lo_re <= s_re[DW:1];
            lo_im <= s_im[DW:1];
            hi_re <= d_re[DW:1];
            hi_im <= d_im[DW:1];
        end
    end

    // Both halved rounds together recover E, or E plus one.
    p_sum_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> ((lo_re + hi_re - $past(e_re)) >= 0 &&
                   (lo_re + hi_re - $past(e_re)) <= 1 &&
                   (lo_im + hi_im - $past(e_im)) >= 0 &&
                   (lo_im + hi_im - $past(e_im)) <= 1));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !o_vld |-> ($stable(lo_re) && $stable(lo_im) && $stable(hi_re) &&
                    $stable(hi_im) && $stable(o_bin)));

endmodule

// File: rtl/fft_final_bfly.sv
// Final radix-2 combiner of a 16-point transform built from two 8-point halves.
// Takes E(k) and O(k) in natural order and emits X(k) and X(k+N/2) together,
// two clocks after each accepted pair. Assumes aligned producers: both valids
// high on the same clock for each bin.
module fft_final_bfly #(
    parameter int DW    = 16,
    parameter int N_PTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_vld,
    input  logic signed [DW-1:0] ev_re,
    input  logic signed [DW-1:0] ev_im,
    input  logic                 od_vld,
    input  logic signed [DW-1:0] od_re,
    input  logic signed [DW-1:0] od_im,
    output logic                 lo_vld,
    output logic signed [DW-1:0] lo_re,
    output logic signed [DW-1:0] lo_im,
    output logic                 hi_vld,
    output logic signed [DW-1:0] hi_re,
    output logic signed [DW-1:0] hi_im,
    output logic [$clog2(N_PTS/2)-1:0] o_bin
);

    localparam int HALF = N_PTS / 2;
    localparam int KW   = $clog2(HALF);

    logic                 pair;
    logic [KW-1:0]        k_cur, k1;
    fbc_pkg::tw_t         w_cur;
    logic                 v1, out_vld;
    logic signed [DW-1:0] e1_re, e1_im, p_re, p_im;

    // A bin is accepted only when both halves present it on the same clock.
    assign pair = ev_vld & od_vld;

    fbc_kcount #(.HALF(HALF), .KW(KW)) u_kcount (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pair),
        .k     (k_cur)
    );

    fbc_twiddle #(.KW(KW)) u_twiddle (
        .k (k_cur),
        .w (w_cur)
    );

    fbc_twmul #(.DW(DW), .KW(KW)) u_twmul (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (pair),
        .k_in  (k_cur),
        .e_re  (ev_re),
        .e_im  (ev_im),
        .o_re  (od_re),
        .o_im  (od_im),
        .w     (w_cur),
        .v1    (v1),
        .k1    (k1),
        .e1_re (e1_re),
        .e1_im (e1_im),
        .p_re  (p_re),
        .p_im  (p_im)
    );

    fbc_addsub #(.DW(DW), .KW(KW)) u_addsub (
        .clk   (clk),
        .rst_n (rst_n),
        .v1    (v1),
        .k1    (k1),
        .e_re  (e1_re),
        .e_im  (e1_im),
        .p_re  (p_re),
        .p_im  (p_im),
        .o_vld (out_vld),
        .o_bin (o_bin),
        .lo_re (lo_re),
        .lo_im (lo_im),
        .hi_re (hi_re),
        .hi_im (hi_im)
    );

    // Both output ports share one valid: the two bins always leave together.
    assign lo_vld = out_vld;
    assign hi_vld = out_vld;

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_vld == $past(pair, 2));

endmodule

// File: tb/test_fft_final_bfly.sv
// Bench: table of operand pairs walked in one loop, then directed tests.
// Expected bins come from a fixed-point model built on the requirement equations.
module test_fft_final_bfly;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int NV         = 16;

    // Operand pairs {E.re, E.im, O.re, O.im}; entries 2 and 10 land on k=2 and clamp (R7).
    localparam int VEC [NV][4] = '{
        '{  1000,  -2000,   3000,   4000},
        '{     0,      0,  16384,      0},
        '{ 32767,  32767,  32767,  32767},
        '{ -5000,   7000, -12000,   9000},
        '{   100,    200,      0,  16384},
        '{-32768, -32768,   1234,  -4321},
        '{ 12345, -23456, -20000,  15000},
        '{     1,      1,      1,      1},
        '{-32768,      0, -32768,      0},
        '{     7,     -7,  32767, -32768},
        '{     0,      0, -32768, -32768},
        '{ 20000,  20000, -20000,  20000},
        '{    -1,     -1,     -1,     -1},
        '{ 30000, -30000,  30000,  30000},
        '{     0,      0,      1,     -1},
        '{-12345,   6789,  32767,      0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic ev_vld, od_vld;
    logic signed [DW-1:0] ev_re, ev_im, od_re, od_im;
    logic lo_vld, hi_vld;
    logic signed [DW-1:0] lo_re, lo_im, hi_re, hi_im;
    logic [2:0] o_bin;

    int nchk = 0;
    int nerr = 0;
    int bench_k = 0;
    int wr = 0;
    int rd = 0;
    bit done = 1'b0;
    bit ok;
    int x_lr [256];
    int x_li [256];
    int x_hr [256];
    int x_hi [256];
    int x_k  [256];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fft_final_bfly i_fft_final_bfly (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_vld (ev_vld),
        .ev_re  (ev_re),
        .ev_im  (ev_im),
        .od_vld (od_vld),
        .od_re  (od_re),
        .od_im  (od_im),
        .lo_vld (lo_vld),
        .lo_re  (lo_re),
        .lo_im  (lo_im),
        .hi_vld (hi_vld),
        .hi_re  (hi_re),
        .hi_im  (hi_im),
        .o_bin  (o_bin)
    );

    function automatic longint rnd(input real r);
        if (r >= 0.0) return longint'($rtoi(r + 0.5));
        else          return -longint'($rtoi(-r + 0.5));
    endfunction

    function automatic longint clip(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32767) return -32767;
        return v;
    endfunction

    // Fixed-point model of R2, R3, R6, R7, R8.
    function automatic void model(input int er, input int ei, input int orr, input int oi,
                                  input int k, output int lr, output int li,
                                  output int hr, output int hi);
        real    ang;
        longint wr_c, wi_c, pr, pim;
        ang  = 2.0 * 3.14159265358979 * k / 16.0;
        wr_c = clip(rnd($cos(ang) * 32768.0));
        wi_c = clip(rnd(-$sin(ang) * 32768.0));
        pr   = longint'(orr) * wr_c - longint'(oi) * wi_c;
        pim  = longint'(orr) * wi_c + longint'(oi) * wr_c;
        pr   = clip((pr + 16384) >>> 15);
        pim  = clip((pim + 16384) >>> 15);
        lr   = int'((longint'(er) + pr + 1) >>> 1);
        li   = int'((longint'(ei) + pim + 1) >>> 1);
        hr   = int'((longint'(er) - pr + 1) >>> 1);
        hi   = int'((longint'(ei) - pim + 1) >>> 1);
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 1) && (b - a <= 1);
    endfunction

    task automatic chk(input bit c, input string tag, input int act, input int exp);
        nchk++;
        if (!c) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives one aligned pair for one clock and books its expected bins.
    task automatic push_pair(input int er, input int ei, input int orr, input int oi);
        int lr, li, hr, hi;
        model(er, ei, orr, oi, bench_k, lr, li, hr, hi);
        x_lr[wr] = lr; x_li[wr] = li; x_hr[wr] = hr; x_hi[wr] = hi; x_k[wr] = bench_k;
        wr++;
        ev_vld = 1'b1; od_vld = 1'b1;
        ev_re = DW'(er); ev_im = DW'(ei); od_re = DW'(orr); od_im = DW'(oi);
        @(negedge clk);
        ev_vld = 1'b0; od_vld = 1'b0;
        bench_k = (bench_k + 1) % 8;
    endtask

    // Scoreboard: every output beat is compared with the next booked bin (R2 R3 R5 R7).
    always @(negedge clk) begin
        if (rst_n && (lo_vld || hi_vld)) begin
            nchk++;
            if (rd >= wr) begin
                nerr++;
                $display("FAIL R4: unexpected output valid, actual=%0d expected=0", lo_vld);
            end else begin
                ok = lo_vld && hi_vld &&
                     near(int'(lo_re), x_lr[rd]) && near(int'(lo_im), x_li[rd]) &&
                     near(int'(hi_re), x_hr[rd]) && near(int'(hi_im), x_hi[rd]) &&
                     (int'(o_bin) == x_k[rd]);
                if (!ok) begin
                    nerr++;
                    $display("FAIL R2/R3/R5/R7: actual lo=(%0d,%0d) hi=(%0d,%0d) k=%0d expected lo=(%0d,%0d) hi=(%0d,%0d) k=%0d",
                             lo_re, lo_im, hi_re, hi_im, o_bin,
                             x_lr[rd], x_li[rd], x_hr[rd], x_hi[rd], x_k[rd]);
                end
                rd++;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int last;
        rst_n = 1'b0;
        ev_vld = 1'b0; od_vld = 1'b0;
        ev_re = '0; ev_im = '0; od_re = '0; od_im = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!lo_vld && !hi_vld, "R1 valids after reset", int'(lo_vld), 0);
        chk(lo_re == 0 && hi_im == 0, "R1 data after reset", int'(lo_re), 0);
        chk(o_bin == 0, "R1 bin after reset", int'(o_bin), 0);

        // Table walk: two full frames of bins, back to back.
        for (int i = 0; i < NV; i++)
            push_pair(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
        repeat (3) @(negedge clk);
        chk(rd == wr, "R2 all table bins delivered", rd, wr);

        // R4: latency of exactly two clocks.
        push_pair(500, -500, 250, 125);
        chk(lo_vld == 1'b0, "R4 no output one clock after pair", int'(lo_vld), 0);
        @(negedge clk);
        chk(lo_vld == 1'b1 && hi_vld == 1'b1, "R4 output two clocks after pair", int'(lo_vld), 1);
        @(negedge clk);

        // R4/R9/R10: lone valids are ignored and outputs hold.
        last = int'(lo_re);
        ev_vld = 1'b1; ev_re = 16'sd9999; ev_im = -16'sd9999;
        repeat (3) @(negedge clk);
        ev_vld = 1'b0;
        od_vld = 1'b1; od_re = -16'sd7777; od_im = 16'sd7777;
        repeat (2) @(negedge clk);
        od_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk(lo_vld == 1'b0, "R4 lone valids give no output", int'(lo_vld), 0);
        chk(int'(lo_re) == last, "R9 output held while idle", int'(lo_re), last);

        // R10: bins keep their order through gaps and across the wrap.
        for (int i = 0; i < 10; i++) begin
            push_pair(i * 1111 - 4000, 3000 - i * 700, 20000 - i * 3500, i * 2900 - 9000);
            repeat (i % 3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(rd == wr, "R10 gapped bins delivered", rd, wr);

        // R1: reset in mid-frame restarts the bin count.
        push_pair(10, 20, 30, 40);
        push_pair(-10, -20, -30, -40);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bench_k = 0;
        @(negedge clk);
        chk(!lo_vld && lo_re == 0 && o_bin == 0, "R1 mid-frame reset clears", int'(lo_re), 0);

        // R6/R8: unity twiddle at k=0, hand-computed rounding.
        push_pair(0, 0, 20000, -10000);
        @(negedge clk);
        chk(lo_re == 16'sd10000 && lo_im == -16'sd5000, "R6 unity twiddle low bin", int'(lo_re), 10000);
        chk(hi_re == -16'sd9999 && hi_im == 16'sd5000, "R8 rounding of high bin", int'(hi_re), -9999);
        chk(o_bin == 3'd0, "R5 first bin after reset", int'(o_bin), 0);
        repeat (3) @(negedge clk);
        chk(rd == wr, "R4 no lost or extra bins", rd, wr);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule